// File: doc/BRIEF.md
# Display Update Rectangle Splitter

This block accepts one screen update rectangle, given as a start column, a start row, a width, a height, a colour-mode field and a set of format flags. It turns it into an ordered stream of transfer sub-requests for a downstream pixel-transfer engine. The engine moves pixels in aligned pairs. The splitter therefore peels off a single leading column when the start column is odd and a single trailing column when one is left over. The even-width span between them goes out as one piece, or as two vertically stacked pieces when it would exceed a byte budget of two bytes per pixel.

Sub-requests leave on a valid/ready handshake. The final one of each rectangle carries a last marker, and a one-cycle completion pulse follows its acceptance. A rectangle is taken only while the block is idle. When a vertical cut is needed, a bit-serial divider computes the height of the upper piece, and no output is offered until it finishes. The tear-sync flag goes only with the first sub-request that leaves, so only that transfer waits on the panel's refresh.

Top module: `rect_splitter`

## Requirements
- R1: `in_ready` is high only when no sub-request is pending, a rectangle is taken on `in_valid && in_ready`, and a sub-request that is offered but not accepted keeps all its fields unchanged until `out_ready`.
- R2: When the start column is odd and the rectangle is non-empty, the first sub-request is one pixel wide and full height at the original column and row, and the later pieces start one column further right with one column less.
- R3: The middle span has the remaining width with bit 0 cleared, starts at the advanced (even) column and the original row, and is emitted only when that width is non-zero.
- R4: When span width × height × 2 is strictly greater than `cfg_max_bytes`, the span is sent as two pieces. The upper piece has height floor(`cfg_max_bytes` / (2 × span width)). The lower piece starts on the row directly below it and covers the remaining rows. When the product is equal or smaller, the span is sent whole.
- R5: When one column remains after the middle span, a final one-pixel-wide, full-height sub-request is emitted at the column just right of the span, on the original row.
- R6: Flag bit 1 (tear-sync) is passed only on the first emitted sub-request and is cleared on every later one. All other flag bits and the colour-mode field are copied unchanged to every sub-request.
- R7: `out_last` is high on exactly the final sub-request of each rectangle, and `done` pulses for one cycle in the cycle after that sub-request is accepted.
- R8: A rectangle with zero width or zero height produces no sub-request, and `done` pulses in the cycle after it is taken.
- R9: Sub-requests leave in the order leading column, upper (or whole) span, lower span, trailing column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Rectangle offered |
| in_ready | output | 1 | Block idle, rectangle can be taken |
| in_x | input | CW | Start column |
| in_y | input | CW | Start row |
| in_w | input | CW | Width in pixels |
| in_h | input | CW | Height in rows |
| in_mode | input | MODEW | Colour-mode field, passed through |
| in_flags | input | FLAGW | Format flags; bit TS_BIT is tear-sync |
| cfg_max_bytes | input | MW | Byte budget of one transfer, sampled with the rectangle |
| out_valid | output | 1 | Sub-request offered |
| out_ready | input | 1 | Consumer accepts the sub-request |
| out_x | output | CW | Sub-request start column |
| out_y | output | CW | Sub-request start row |
| out_w | output | CW | Sub-request width |
| out_h | output | CW | Sub-request height |
| out_mode | output | MODEW | Colour mode of the sub-request |
| out_flags | output | FLAGW | Flags of the sub-request |
| out_last | output | 1 | Final sub-request of the rectangle |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the checker enforces the handshake rules: idle-only acceptance and held sub-requests. It also requires that no empty sub-request appears, that every wide sub-request is even in both column and width, that tear-sync never follows an accepted non-final piece, and that completion comes right after the last piece. The actual split geometry cannot be checked as a per-cycle property. That covers the odd lead, the cut height from the divider, the exact-budget boundary, the trailing column and the ordering. The scoreboard checks it against a model under odd and even starts, single- and two-column widths, cut and uncut spans, empty rectangles and a stuttering consumer.

// File: rtl/rect_splitter.sv
module rect_splitter #(
  parameter int CW     = 11,
  parameter int MW     = 20,
  parameter int MODEW  = 2,
  parameter int FLAGW  = 3,
  parameter int TS_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CW-1:0]    in_x,
  input  logic [CW-1:0]    in_y,
  input  logic [CW-1:0]    in_w,
  input  logic [CW-1:0]    in_h,
  input  logic [MODEW-1:0] in_mode,
  input  logic [FLAGW-1:0] in_flags,
  input  logic [MW-1:0]    cfg_max_bytes,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CW-1:0]    out_x,
  output logic [CW-1:0]    out_y,
  output logic [CW-1:0]    out_w,
  output logic [CW-1:0]    out_h,
  output logic [MODEW-1:0] out_mode,
  output logic [FLAGW-1:0] out_flags,
  output logic             out_last,
  output logic             done
);

  localparam int PW   = (2*CW+1 > MW) ? 2*CW+1 : MW;
  localparam int RW   = CW + 2;
  localparam int CNTW = $clog2(MW+1);

  typedef enum logic [2:0] {S_IDLE, S_DIV, S_LEAD, S_MID1, S_MID2, S_TAIL} st_t;

  st_t st, st_nx_emit, st_first_in;

  logic [CW-1:0]    rx, ry, rh, span;
  logic [MODEW-1:0] rmode;
  logic [FLAGW-1:0] rflags;
  logic             lead, tail, cut, first;
  logic [MW-1:0]    quo;
  logic [RW-1:0]    rem;
  logic [CNTW-1:0]  cnt;

  logic             nz_in, lead_in, tail_in, cut_in, take, fire;
  logic [CW-1:0]    w1_in, span_in, xa, qh;
  logic [PW-1:0]    prod_in;
  logic [RW:0]      trial, dvs;

  assign in_ready = (st == S_IDLE);
  assign take     = in_valid && in_ready;
  assign fire     = out_valid && out_ready;

  assign nz_in   = (in_w != '0) && (in_h != '0);
  assign lead_in = in_x[0] && nz_in;
  assign w1_in   = in_w - CW'(lead_in);
  assign span_in = nz_in ? {w1_in[CW-1:1], 1'b0} : '0;
  assign tail_in = w1_in[0] && nz_in;
  assign prod_in = PW'(span_in) * PW'(in_h) * PW'(2);
  assign cut_in  = (span_in != '0) && (prod_in > PW'(cfg_max_bytes));

  always_comb begin
    if (lead_in)              st_first_in = S_LEAD;
    else if (span_in != '0)   st_first_in = S_MID1;
    else if (tail_in)         st_first_in = S_TAIL;
    else                      st_first_in = S_IDLE;
  end

  always_comb begin
    st_nx_emit = S_IDLE;
    case (st)
      S_LEAD: st_nx_emit = (span != '0) ? S_MID1 : (tail ? S_TAIL : S_IDLE);
      S_MID1: st_nx_emit = cut ? S_MID2 : (tail ? S_TAIL : S_IDLE);
      S_MID2: st_nx_emit = tail ? S_TAIL : S_IDLE;
      default: st_nx_emit = S_IDLE;
    endcase
  end

  assign trial = {rem, quo[MW-1]};
  assign dvs   = (RW+1)'({span, 1'b0});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rx <= '0; ry <= '0; rh <= '0; span <= '0;
      rmode <= '0; rflags <= '0;
      lead <= 1'b0; tail <= 1'b0; cut <= 1'b0; first <= 1'b0;
      quo <= '0; rem <= '0; cnt <= '0;
      done <= 1'b0;
    end else begin
      done <= (take && !nz_in) || (fire && out_last);
      if (take) begin
        rx <= in_x; ry <= in_y; rh <= in_h;
        span <= span_in; lead <= lead_in; tail <= tail_in; cut <= cut_in;
        rmode <= in_mode; rflags <= in_flags;
        first <= 1'b1;
        quo <= cfg_max_bytes;
        rem <= '0;
        cnt <= CNTW'(MW);
        st <= cut_in ? S_DIV : st_first_in;
      end else if (st == S_DIV) begin
        if (trial >= dvs) begin
          rem <= RW'(trial - dvs);
          quo <= {quo[MW-2:0], 1'b1};
        end else begin
          rem <= RW'(trial);
          quo <= {quo[MW-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CNTW'(1)) st <= lead ? S_LEAD : S_MID1;
      end else if (fire) begin
        first <= 1'b0;
        st <= st_nx_emit;
      end
    end
  end

  assign qh = CW'(quo);
  assign xa = rx + CW'(lead);

  assign out_valid = (st == S_LEAD) || (st == S_MID1) || (st == S_MID2) || (st == S_TAIL);
  assign out_last  = out_valid && (st_nx_emit == S_IDLE);
  assign out_mode  = rmode;
  assign out_flags = first ? rflags : (rflags & ~(FLAGW'(1) << TS_BIT));

  always_comb begin
    out_x = rx; out_y = ry; out_w = CW'(1); out_h = rh;
    case (st)
      S_MID1: begin out_x = xa; out_w = span; out_h = cut ? qh : rh; end
      S_MID2: begin out_x = xa; out_y = ry + qh; out_w = span; out_h = rh - qh; end
      S_TAIL: begin out_x = xa + span; end
      default: ;
    endcase
  end

endmodule

// File: rtl/rect_splitter_chk.sv
module rect_splitter_chk #(
  parameter int CW     = 11,
  parameter int FLAGW  = 3,
  parameter int TS_BIT = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CW-1:0]    out_x,
  input logic [CW-1:0]    out_y,
  input logic [CW-1:0]    out_w,
  input logic [CW-1:0]    out_h,
  input logic [FLAGW-1:0] out_flags,
  input logic             out_last,
  input logic             done
);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y)
      && $stable(out_w) && $stable(out_h) && $stable(out_flags) && $stable(out_last));

  assert_idle_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  assert_even_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_w != CW'(1) |-> !out_w[0] && !out_x[0]);

  assert_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_w != '0 && out_h != '0);

  assert_ts_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && !out_flags[TS_BIT]);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

endmodule

bind rect_splitter rect_splitter_chk #(.CW(CW), .FLAGW(FLAGW), .TS_BIT(TS_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_x(out_x), .out_y(out_y), .out_w(out_w),
  .out_h(out_h), .out_flags(out_flags), .out_last(out_last), .done(done)
);

// File: tb/tb_rect_splitter.sv
module tb_rect_splitter;
  localparam int CW = 11, MW = 20, MODEW = 2, FLAGW = 3, TS = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [CW-1:0] in_x = '0, in_y = '0, in_w = '0, in_h = '0;
  logic [MODEW-1:0] in_mode = '0;
  logic [FLAGW-1:0] in_flags = '0;
  logic [MW-1:0] cfg_max_bytes = '0;
  logic in_ready, out_valid, out_last, done;
  logic [CW-1:0] out_x, out_y, out_w, out_h;
  logic [MODEW-1:0] out_mode;
  logic [FLAGW-1:0] out_flags;

  always #2 clk = ~clk;

  rect_splitter #(.CW(CW), .MW(MW), .MODEW(MODEW), .FLAGW(FLAGW), .TS_BIT(TS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_w(in_w), .in_h(in_h), .in_mode(in_mode),
    .in_flags(in_flags), .cfg_max_bytes(cfg_max_bytes), .out_valid(out_valid),
    .out_ready(out_ready), .out_x(out_x), .out_y(out_y), .out_w(out_w),
    .out_h(out_h), .out_mode(out_mode), .out_flags(out_flags),
    .out_last(out_last), .done(done));

  typedef struct { int x, y, w, h, mode, flags, last, tag; } item_t;
  item_t expq[$];
  item_t stage[$];
  bit stage_first;
  int n_chk = 0, n_fail = 0, done_cnt = 0, exp_done = 0;
  int ready_mode = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic add_item(input int x, y, w, h, mode, flags, tag);
    item_t it;
    it.x = x; it.y = y; it.w = w; it.h = h; it.mode = mode;
    it.flags = stage_first ? flags : (flags & ~(1 << TS));
    it.last = 0; it.tag = tag;
    stage_first = 0;
    stage.push_back(it);
  endtask

  // Model: R2 lead, R3/R4 span, R5 tail, R6 flags, R7 last, R8 empty, R9 order
  task automatic send(input int x, y, w, h, mode, flags, maxb);
    int cx, cw, span, q;
    stage.delete();
    stage_first = 1;
    cx = x; cw = w;
    if (w > 0 && h > 0) begin
      if (cx % 2 == 1) begin add_item(cx, y, 1, h, mode, flags, 2); cx++; cw--; end
      span = cw & ~1;
      if (span != 0) begin
        if (span * h * 2 > maxb) begin
          q = maxb / (span * 2);
          add_item(cx, y, span, q, mode, flags, 4);
          add_item(cx, y + q, span, h - q, mode, flags, 4);
        end else add_item(cx, y, span, h, mode, flags, 3);
        cx += span; cw -= span;
      end
      if (cw != 0) add_item(cx, y, 1, h, mode, flags, 5);
    end
    if (stage.size() > 0) stage[stage.size()-1].last = 1;
    foreach (stage[i]) expq.push_back(stage[i]);
    exp_done++;
    @(posedge clk); #1;
    in_valid = 1'b1; in_x = CW'(x); in_y = CW'(y); in_w = CW'(w); in_h = CW'(h);
    in_mode = MODEW'(mode); in_flags = FLAGW'(flags); cfg_max_bytes = MW'(maxb);
    forever begin @(negedge clk); if (in_ready) break; end
    @(posedge clk); #1;
    in_valid = 1'b0;
    while (expq.size() != 0 || done_cnt != exp_done) @(negedge clk);
    @(negedge clk);
    chk(done_cnt == exp_done && expq.size() == 0, (w == 0 || h == 0) ? "R8" : "R7",
        $sformatf("completion count got %0d exp %0d", done_cnt, exp_done));
  endtask

  always @(posedge clk) begin
    #1;
    if (ready_mode == 0) out_ready = 1'b1;
    else out_ready = ($urandom % 3) != 0;
  end

  logic hold_v = 0;
  logic [CW-1:0] hx, hy, hw, hh;
  logic [FLAGW-1:0] hf;
  logic hl;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) done_cnt++;
      if (hold_v)
        chk(out_valid && out_x == hx && out_y == hy && out_w == hw && out_h == hh
            && out_flags == hf && out_last == hl, "R1",
            $sformatf("held item changed got (%0d,%0d,%0d,%0d) exp (%0d,%0d,%0d,%0d)",
                      out_x, out_y, out_w, out_h, hx, hy, hw, hh));
      hold_v = out_valid && !out_ready;
      hx = out_x; hy = out_y; hw = out_w; hh = out_h; hf = out_flags; hl = out_last;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(0, "R9", $sformatf("unexpected item (%0d,%0d,%0d,%0d) exp none",
                                                 out_x, out_y, out_w, out_h));
        else begin
          item_t e;
          e = expq.pop_front();
          chk(int'(out_x) == e.x && int'(out_y) == e.y && int'(out_w) == e.w &&
              int'(out_h) == e.h && int'(out_mode) == e.mode &&
              int'(out_flags) == e.flags && int'(out_last) == e.last,
              $sformatf("R%0d", e.tag),
              $sformatf("got x%0d y%0d w%0d h%0d m%0d f%0d l%0d exp x%0d y%0d w%0d h%0d m%0d f%0d l%0d",
                        out_x, out_y, out_w, out_h, out_mode, out_flags, out_last,
                        e.x, e.y, e.w, e.h, e.mode, e.flags, e.last));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, got hang exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready && !done, "R1",
        $sformatf("reset state got v%0d r%0d d%0d exp v0 r1 d0", out_valid, in_ready, done));
    send(3, 5, 10, 4, 1, 3'b011, 4096);    // R2 lead, R3 span, R5 tail, R6
    send(4, 7, 8, 3, 2, 3'b110, 4096);     // R3 single span, R7 last
    send(2, 10, 6, 20, 3, 3'b010, 100);    // R4 cut q=8
    send(0, 0, 10, 5, 0, 3'b011, 100);     // R4 product equals budget: no cut
    send(9, 2, 1, 6, 1, 3'b010, 4096);     // R2 lead only
    send(5, 1, 2, 3, 2, 3'b111, 4096);     // R2 lead + R5 tail, no span
    send(6, 6, 0, 4, 0, 3'b010, 4096);     // R8 zero width
    send(6, 6, 4, 0, 0, 3'b010, 4096);     // R8 zero height
    ready_mode = 1;
    send(7, 0, 20, 50, 3, 3'b011, 300);    // R9 full order with cut, stalled consumer
    for (int i = 0; i < 20; i++)
      send($urandom_range(0, 200), $urandom_range(0, 200), $urandom_range(0, 40),
           $urandom_range(0, 30), $urandom_range(0, 3), $urandom_range(0, 7),
           $urandom_range(80, 3000));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule